// File: doc/BRIEF.md
# Host Keyboard-Controller Mailbox with Update-Mode Commands

This block is the controller end of an 8042-style host mailbox. The host bus reaches it through byte-wide I/O reads and writes at two addresses. One is a data port at 0x60. The other is a command/status port at 0x64. Each direction has a single one-byte buffer with a full flag. The host polls these flags through the status byte.

Bytes the host writes to the data port wait in the input buffer until the controller logic pops them. Bytes the host writes to the command port go to a built-in command decoder. The decoder consumes each command a fixed, parameterised number of cycles after the write, so host polling loops see a busy input buffer for a while. Two commands switch execution between normal (flash) mode and a scratch-RAM update mode. Entry is acknowledged with a fixed byte in the output buffer. An exit command that arrives while already in normal mode becomes a one-cycle system-reset request. The controller logic can also push its own bytes into the output buffer.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the block is in normal mode (`update_mode_o` low), both buffer-full flags are clear and `sys_reset_req_o` is low.
- R2: Reading address 0x64 returns the status byte: bit 0 is the output-buffer-full flag, bit 1 is the input-buffer-full flag, and bits 7..2 are zero. Status reads have no side effect.
- R3: A host write to 0x60 or 0x64 while the input buffer is empty stores the byte and sets the input-buffer-full flag. A write while the flag is set is dropped and leaves the stored byte unchanged. Writes to any other address are ignored.
- R4: A data-port byte is presented on `ctl_in_byte_o` with `ctl_in_valid_o` high. A pulse on `ctl_pop_i` consumes it and clears the input-buffer-full flag at the next edge.
- R5: A command-port byte is never presented to the controller (`ctl_in_valid_o` stays low). The decoder consumes it so that the input-buffer-full flag reads set for exactly `CMD_DELAY` cycles (1 to 255) after the write edge.
- R6: Command 0xB4 puts the block in update mode and loads 0xFA into the output buffer, which sets the output-buffer-full flag. This holds even when the block is already in update mode.
- R7: Command 0xFE received in update mode returns the block to normal mode without a reset request.
- R8: Command 0xFE received in normal mode raises `sys_reset_req_o` for exactly one cycle and leaves the mode unchanged.
- R9: Any other command byte is consumed (the input flag clears) with no reply, no mode change and no reset request.
- R10: A `ctl_push_i` pulse while the output buffer is empty loads `ctl_push_data_i` and sets the output-buffer-full flag. A push while the flag is set is ignored. A decoder reply takes priority over a push in the same cycle.
- R11: Reading address 0x60 returns the output byte and clears the output-buffer-full flag. Reading it when the flag is already clear returns the last byte and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | ADDR_W | Host I/O address |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Host read data, combinational on the address |
| ctl_in_valid_o | output | 1 | Data-port byte waiting for the controller |
| ctl_in_byte_o | output | 8 | Waiting input byte |
| ctl_pop_i | input | 1 | Consume the waiting data byte |
| ctl_push_i | input | 1 | Load a byte into the output buffer |
| ctl_push_data_i | input | 8 | Byte to load |
| ctl_out_full_o | output | 1 | Output buffer occupied |
| update_mode_o | output | 1 | High while in scratch-RAM update mode |
| sys_reset_req_o | output | 1 | One-cycle system-reset request |

## Verification
The bench builds the block with `CMD_DELAY` = 4. That value is long enough that a host poll of the status byte catches the input flag set across several cycles, and the count of busy cycles is checked exactly. It is also short enough for the command sequences to finish quickly. Together with the default of 8 used in elaboration, it shows the consume delay is a true parameter rather than a fixed pipeline. The bench enters update mode, re-enters it, exits it, and sends both an unknown command and an exit command in normal mode. It counts reset-request cycles on every negative edge, so a held request would be caught.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam logic [7:0] CMD_ENTER_UPD = 8'hB4;
  localparam logic [7:0] CMD_EXIT_UPD  = 8'hFE;
  localparam logic [7:0] REPLY_ACK     = 8'hFA;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_UPDATE = 1'b1
  } exec_mode_e;
endpackage

// File: rtl/kbc_in_buf.sv
module kbc_in_buf #(
  parameter int CMD_DELAY = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       is_cmd_i,
  input  logic [7:0] wdata_i,
  input  logic       pop_i,
  output logic       full_o,
  output logic       is_cmd_o,
  output logic [7:0] byte_o,
  output logic       cmd_take_o
);
  localparam int CNT_W = $clog2(CMD_DELAY + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             full_q, cmd_q;
  logic [7:0]       byte_q;

  assign cmd_take_o = full_q && cmd_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      cmd_q  <= 1'b0;
      byte_q <= '0;
      cnt_q  <= '0;
    end else if (!full_q) begin
      if (wr_i) begin
        full_q <= 1'b1;
        cmd_q  <= is_cmd_i;
        byte_q <= wdata_i;
        cnt_q  <= CNT_W'(CMD_DELAY);
      end
    end else if (cmd_q) begin
      if (cmd_take_o) full_q <= 1'b0;
      else            cnt_q  <= cnt_q - CNT_W'(1);
    end else if (pop_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o   = full_q;
  assign is_cmd_o = cmd_q;
  assign byte_o   = byte_q;
endmodule

// File: rtl/kbc_cmd_dec.sv
module kbc_cmd_dec
  import kbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic [7:0] cmd_i,
  output logic       reply_o,
  output logic       update_mode_o,
  output logic       reset_req_o
);
  exec_mode_e mode_q;
  logic       req_q;
  logic       is_enter, is_exit;

  assign is_enter = take_i && (cmd_i == CMD_ENTER_UPD);
  assign is_exit  = take_i && (cmd_i == CMD_EXIT_UPD);
  assign reply_o  = is_enter;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL;
      req_q  <= 1'b0;
    end else begin
      req_q <= is_exit && (mode_q == MODE_NORMAL);
      if (is_enter)     mode_q <= MODE_UPDATE;
      else if (is_exit) mode_q <= MODE_NORMAL;
    end
  end

  assign update_mode_o = (mode_q == MODE_UPDATE);
  assign reset_req_o   = req_q;
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
  import kbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reply_i,
  input  logic       push_i,
  input  logic [7:0] push_data_i,
  input  logic       host_take_i,
  output logic       full_o,
  output logic [7:0] byte_o
);
  logic       full_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      byte_q <= '0;
    end else if (reply_i) begin
      full_q <= 1'b1;
      byte_q <= REPLY_ACK;
    end else if (push_i && !full_q) begin
      full_q <= 1'b1;
      byte_q <= push_data_i;
    end else if (host_take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign byte_o = byte_q;
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox #(
  parameter int                 ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  DATA_PORT = ADDR_W'(8'h60),
  parameter logic [ADDR_W-1:0]  CMD_PORT  = ADDR_W'(8'h64),
  parameter int                 CMD_DELAY = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wr_i,
  input  logic [7:0]        host_wdata_i,
  input  logic              host_rd_i,
  output logic [7:0]        host_rdata_o,
  output logic              ctl_in_valid_o,
  output logic [7:0]        ctl_in_byte_o,
  input  logic              ctl_pop_i,
  input  logic              ctl_push_i,
  input  logic [7:0]        ctl_push_data_i,
  output logic              ctl_out_full_o,
  output logic              update_mode_o,
  output logic              sys_reset_req_o
);
  logic       sel_data, sel_cmd;
  logic       ibf, in_is_cmd, cmd_take, reply, obf;
  logic [7:0] in_byte, out_byte;

  assign sel_data = (host_addr_i == DATA_PORT);
  assign sel_cmd  = (host_addr_i == CMD_PORT);

  kbc_in_buf #(.CMD_DELAY(CMD_DELAY)) u_in (
    .clk_i, .rst_ni,
    .wr_i      (host_wr_i && (sel_data || sel_cmd)),
    .is_cmd_i  (sel_cmd),
    .wdata_i   (host_wdata_i),
    .pop_i     (ctl_pop_i),
    .full_o    (ibf),
    .is_cmd_o  (in_is_cmd),
    .byte_o    (in_byte),
    .cmd_take_o(cmd_take)
  );

  kbc_cmd_dec u_dec (
    .clk_i, .rst_ni,
    .take_i       (cmd_take),
    .cmd_i        (in_byte),
    .reply_o      (reply),
    .update_mode_o(update_mode_o),
    .reset_req_o  (sys_reset_req_o)
  );

  kbc_out_buf u_out (
    .clk_i, .rst_ni,
    .reply_i    (reply),
    .push_i     (ctl_push_i),
    .push_data_i(ctl_push_data_i),
    .host_take_i(host_rd_i && sel_data),
    .full_o     (obf),
    .byte_o     (out_byte)
  );

  always_comb begin
    if (sel_cmd)       host_rdata_o = {6'b0, ibf, obf};
    else if (sel_data) host_rdata_o = out_byte;
    else               host_rdata_o = 8'h00;
  end

  assign ctl_in_valid_o = ibf && !in_is_cmd;
  assign ctl_in_byte_o  = in_byte;
  assign ctl_out_full_o = obf;
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(8'h60),
  parameter logic [ADDR_W-1:0] CMD_PORT  = ADDR_W'(8'h64)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic              ctl_in_valid_o,
  input logic [7:0]        ctl_in_byte_o,
  input logic              ctl_pop_i,
  input logic              ctl_out_full_o,
  input logic [7:0]        host_rdata_o,
  input logic              update_mode_o,
  input logic              sys_reset_req_o,
  input logic              ibf,
  input logic              reply
);
  a_r3_write_sets_ibf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && (host_addr_i == DATA_PORT || host_addr_i == CMD_PORT) |=> ibf);

  a_r3_held_byte_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_in_valid_o && !ctl_pop_i |=> ctl_in_valid_o && $stable(ctl_in_byte_o));

  a_r4_pop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_in_valid_o && ctl_pop_i |=> !ibf);

  a_r6_enter_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply |=> update_mode_o && ctl_out_full_o);

  a_r7_exit_no_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(update_mode_o) |-> !sys_reset_req_o);

  a_r8_reset_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_o |=> !sys_reset_req_o);

  a_r8_reset_only_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_o |-> !update_mode_o);

  a_r11_read_clears_obf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && host_addr_i == DATA_PORT && !reply |=> !ctl_out_full_o);

  // R2: upper status bits always zero
  a_r2_status_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_addr_i == CMD_PORT |-> host_rdata_o[7:2] == 6'b0);
endmodule

bind kbc_mailbox kbc_mailbox_chk #(
  .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_addr_i(host_addr_i),
  .host_wr_i(host_wr_i), .host_rd_i(host_rd_i),
  .ctl_in_valid_o(ctl_in_valid_o), .ctl_in_byte_o(ctl_in_byte_o),
  .ctl_pop_i(ctl_pop_i), .ctl_out_full_o(ctl_out_full_o),
  .host_rdata_o(host_rdata_o), .update_mode_o(update_mode_o),
  .sys_reset_req_o(sys_reset_req_o), .ibf(ibf), .reply(reply)
);

// File: tb/kbc_mailbox_tb.sv
module kbc_mailbox_tb;
  localparam int DLY = 4;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WT = 2'd2;
  localparam int NV = 15;
  // {op, addr, data, expected rdata, expected mode}
  localparam logic [26:0] TBL [0:NV-1] = '{
    {OP_WR, 8'h64, 8'hB4, 8'h00, 1'b0},
    {OP_WT, 8'h00, 8'd4,  8'h00, 1'b0},
    {OP_RD, 8'h64, 8'h00, 8'h01, 1'b1},  // R6 R2
    {OP_RD, 8'h60, 8'h00, 8'hFA, 1'b1},  // R6 R11
    {OP_RD, 8'h64, 8'h00, 8'h00, 1'b1},  // R11
    {OP_WR, 8'h64, 8'hB4, 8'h00, 1'b0},
    {OP_WT, 8'h00, 8'd4,  8'h00, 1'b0},
    {OP_RD, 8'h60, 8'h00, 8'hFA, 1'b1},  // R6 re-entry
    {OP_WR, 8'h64, 8'hFE, 8'h00, 1'b0},
    {OP_WT, 8'h00, 8'd4,  8'h00, 1'b0},
    {OP_RD, 8'h64, 8'h00, 8'h00, 1'b0},  // R7
    {OP_WR, 8'h64, 8'h5C, 8'h00, 1'b0},
    {OP_RD, 8'h64, 8'h00, 8'h02, 1'b0},  // R9 busy
    {OP_WT, 8'h00, 8'd4,  8'h00, 1'b0},
    {OP_RD, 8'h64, 8'h00, 8'h00, 1'b0}   // R9 no reply
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata, in_byte, push_data = 8'h00;
  logic wr = 0, rd = 0, pop = 0, push = 0;
  logic in_valid, out_full, upd, rreq;
  int   errors = 0, checks = 0, pulses = 0, cyc = 0;

  always #4 clk = ~clk;

  kbc_mailbox #(.CMD_DELAY(DLY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_wr_i(wr),
    .host_wdata_i(wdata), .host_rd_i(rd), .host_rdata_o(rdata),
    .ctl_in_valid_o(in_valid), .ctl_in_byte_o(in_byte), .ctl_pop_i(pop),
    .ctl_push_i(push), .ctl_push_data_i(push_data), .ctl_out_full_o(out_full),
    .update_mode_o(upd), .sys_reset_req_o(rreq)
  );

  always @(negedge clk) begin
    cyc++;
    if (rreq) pulses++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic status(output logic [7:0] s);
    addr = 8'h64; #1 s = rdata;
  endtask

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    // R1 reset state
    status(s);
    chk("R1 status", s, 8'h00);
    chk("R1 mode/req", {6'b0, upd, rreq}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i][26:25])
        OP_WR: host_wr(TBL[i][24:17], TBL[i][16:9]);
        OP_WT: repeat (int'(TBL[i][16:9])) @(negedge clk);
        default: begin
          addr = TBL[i][24:17]; rd = 1; #1;
          chk($sformatf("R2/R6/R7/R9/R11 vec%0d rdata", i), rdata, TBL[i][8:1]);
          chk($sformatf("R6/R7 vec%0d mode", i), {7'b0, upd}, {7'b0, TBL[i][0]});
          @(negedge clk); rd = 0;
        end
      endcase
    end
    chk("R7 no reset pulse in table", 8'(pulses), 8'd0);

    // R5: exact busy window for a command, never shown to controller
    begin
      int n = 0; int seen = 0;
      host_wr(8'h64, 8'h33);
      status(s);
      while (s[1] && n < 300) begin
        if (in_valid) seen++;
        n++; @(negedge clk); status(s);
      end
      chk("R5 busy cycles", 8'(n), 8'(DLY));
      chk("R5 valid hidden", 8'(seen), 8'd0);
    end

    // R8: exit while normal
    host_wr(8'h64, 8'hFE);
    repeat (DLY + 2) @(negedge clk);
    chk("R8 one-cycle reset req", 8'(pulses), 8'd1);
    chk("R8 mode unchanged", {7'b0, upd}, 8'h00);

    // R3/R4: data byte, drop on full, pop
    host_wr(8'h60, 8'h11);
    chk("R4 valid", {7'b0, in_valid}, 8'h01);
    status(s); chk("R3 ibf set", s, 8'h02);
    host_wr(8'h60, 8'h22);
    chk("R3 dropped write", in_byte, 8'h11);
    pop = 1; @(negedge clk); pop = 0;
    chk("R4 pop clears valid", {7'b0, in_valid}, 8'h00);
    status(s); chk("R4 ibf clear", s, 8'h00);
    host_wr(8'h61, 8'h77);
    status(s); chk("R3 other addr ignored", s, 8'h00);

    // R10: push, push on full ignored, read back
    push_data = 8'hA5; push = 1; @(negedge clk);
    push_data = 8'h5A; @(negedge clk); push = 0;
    status(s); chk("R10 obf set", s, 8'h01);
    addr = 8'h60; rd = 1; #1;
    chk("R10 push on full ignored", rdata, 8'hA5);
    @(negedge clk); rd = 0;
    // R11: read when empty
    addr = 8'h60; rd = 1; #1;
    chk("R11 empty read keeps byte", rdata, 8'hA5);
    @(negedge clk); rd = 0;
    status(s); chk("R11 obf stays clear", s, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule